// File: doc/BRIEF.md
# Selectable Three-Bank Clock Divider

This block takes one fast source clock and derives thirteen slower clocks from it. There are three banks of four lanes and one feedback lane. Each bank and the feedback lane has its own ratio select code. A shared range bit puts an extra divide-by-two ahead of every divider. All ratios are even, so every derived clock has an exact 50% duty cycle, counted in source edges.

The source is either the fast oscillator clock or, in bypass, the reference clock. The selection is made by `pll_on`. One active-low pin does two jobs: it holds every divider cleared and floats every output. When that pin is released, all dividers restart together, so the first rising edges of all lanes fall on the same source edge. One control can flip the upper two lanes of bank C by half a period.

A new select or range value is never applied in the middle of a period. Each divider finishes its current period at the old ratio. It picks up the new ratio only when its count wraps, so no short pulse appears on any lane. The block has no data stream, so all pins are plain control and clock pins.

Top module: `tribank_clk_div`

## Requirements
- R1: Bank A lanes `qa[3:0]` all carry the same clock. `sel_a` codes 0,1,2,3 divide by 4,6,8,12 when `range_hi`=1.
- R2: Bank B lanes `qb[3:0]` all carry the same clock. `sel_b` codes 0,1,2,3 divide by 4,6,8,10 when `range_hi`=1.
- R3: Bank C lanes `qc[1:0]` carry the same clock. `sel_c` codes 0,1,2,3 divide by 2,4,6,8 when `range_hi`=1.
- R4: `q_fb` uses the 3-bit `sel_fb`. Codes 0 to 7 divide by 4,6,8,10,8,12,16,20 when `range_hi`=1.
- R5: With `range_hi`=0, every ratio in R1 to R4 is doubled.
- R6: For a ratio N, each lane is high for N/2 source edges and then low for N/2 source edges. The high half comes first.
- R7: On the first source rising edge after `rst_oe_n` goes high, every lane goes high on that same edge.
- R8: While `rst_oe_n`=0, no lane drives high (all outputs float) and every divider stays cleared. After release, R7 applies again.
- R9: With `pll_on`=0, the dividers count `ref_clk` rising edges and `vco_clk` edges have no effect. With `pll_on`=1, they count `vco_clk` edges.
- R10: With `c_invert`=1, `qc[3:2]` are the complement of `qc[1:0]`. With `c_invert`=0, `qc[3:2]` equal `qc[1:0]`.
- R11: A change of select or range finishes the current output period at the old ratio. The new ratio starts with the next period, which begins high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock, the source when `pll_on`=1 |
| ref_clk | input | 1 | Reference clock, the source in bypass |
| pll_on | input | 1 | 1 selects `vco_clk`, 0 selects `ref_clk` |
| rst_oe_n | input | 1 | Active-low clear of all dividers and output float |
| range_hi | input | 1 | 0 adds a divide-by-two to every ratio |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| c_invert | input | 1 | 1 inverts `qc[3:2]` |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks |
| q_fb | output | 1 | Feedback clock |

## Verification
The hardest case to reach is a select change that lands mid-period, including changes made on the very edge where a divider wraps. That is the only place a short pulse could appear, and only when phases and ratios differ across lanes. The bench lets all lanes run from random configurations. It changes random selects and the range bit at random edge counts, so changes fall before, on and after the wrap edges of lanes with different periods. Bypass is also awkward to observe, because the unused clock must be shown to do nothing. The bench therefore toggles `vco_clk` between reference edges and checks that every lane holds still.

// File: rtl/tribank_pkg.sv
package tribank_pkg;

  typedef enum logic [1:0] {
    PATH_A  = 2'd0,
    PATH_B  = 2'd1,
    PATH_C  = 2'd2,
    PATH_FB = 2'd3
  } path_e;

  localparam int NUM_PATHS = 4;
  localparam int CODE_W    = 3;

  // half period in source edges with the range bit set
  function automatic int unsigned base_half(path_e p, logic [CODE_W-1:0] code);
    int unsigned h;
    h = 1;
    unique case (p)
      PATH_A: begin
        unique case (code[1:0])
          2'd0: h = 2;
          2'd1: h = 3;
          2'd2: h = 4;
          default: h = 6;
        endcase
      end
      PATH_B: h = 2 + 32'(code[1:0]);
      PATH_C: h = 1 + 32'(code[1:0]);
      default: begin
        h = 2 + 32'(code[1:0]);
        if (code[2]) h = h * 2;
      end
    endcase
    return h;
  endfunction

endpackage

// File: rtl/clk_src_pick.sv
module clk_src_pick (
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic use_vco,
  output logic src_clk
);
  assign src_clk = use_vco ? vco_clk : ref_clk;
endmodule

// File: rtl/half_lookup.sv
module half_lookup
  import tribank_pkg::*;
#(
  parameter int PATH   = 0,
  parameter int HALF_W = 5
) (
  input  logic [CODE_W-1:0] code,
  input  logic              range_hi,
  output logic [HALF_W-1:0] half
);
  localparam path_e KIND = path_e'(PATH);

  int unsigned b;
  always_comb begin
    b = base_half(KIND, code);
    if (!range_hi) b = b * 2;
    half = HALF_W'(b);
  end
endmodule

// File: rtl/even_clk_div.sv
module even_clk_div #(
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_sel,
  output logic              clk_out,
  output logic              live
);
  localparam int CNT_W = HALF_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic [HALF_W-1:0] h_q;
  logic [HALF_W-1:0] hh;

  assign hh   = live ? h_q : half_sel;
  assign last = {h_q, 1'b0} - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      h_q     <= '0;
      live    <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      clk_out <= (cnt < {1'b0, hh});
      if (!live) begin
        live <= 1'b1;
        h_q  <= half_sel;
        cnt  <= CNT_W'(1);
      end else if (cnt == last) begin
        cnt <= '0;
        h_q <= half_sel;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  p_half_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (h_q != '0));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (cnt < {h_q, 1'b0}));

  p_reload_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live) && (h_q != $past(h_q))) |-> (cnt == '0));
endmodule

// File: rtl/tribank_clk_div.sv
module tribank_clk_div
  import tribank_pkg::*;
#(
  parameter int HALF_W = 5,
  parameter int LANES  = 4
) (
  input  logic             vco_clk,
  input  logic             ref_clk,
  input  logic             pll_on,
  input  logic             rst_oe_n,
  input  logic             range_hi,
  input  logic [1:0]       sel_a,
  input  logic [1:0]       sel_b,
  input  logic [1:0]       sel_c,
  input  logic [2:0]       sel_fb,
  input  logic             c_invert,
  output logic [LANES-1:0] qa,
  output logic [LANES-1:0] qb,
  output logic [LANES-1:0] qc,
  output logic             q_fb
);
  localparam int HALF_LANES = LANES / 2;

  logic src_clk;
  logic [CODE_W-1:0] code [NUM_PATHS];
  logic [NUM_PATHS-1:0] div_out;
  logic [NUM_PATHS-1:0] div_live;

  clk_src_pick u_pick (
    .vco_clk (vco_clk),
    .ref_clk (ref_clk),
    .use_vco (pll_on),
    .src_clk (src_clk)
  );

  assign code[0] = {1'b0, sel_a};
  assign code[1] = {1'b0, sel_b};
  assign code[2] = {1'b0, sel_c};
  assign code[3] = sel_fb;

  for (genvar d = 0; d < NUM_PATHS; d++) begin : g_path
    logic [HALF_W-1:0] half;
    half_lookup #(.PATH(d), .HALF_W(HALF_W)) u_lut (
      .code     (code[d]),
      .range_hi (range_hi),
      .half     (half)
    );
    even_clk_div #(.HALF_W(HALF_W)) u_div (
      .clk      (src_clk),
      .rst_n    (rst_oe_n),
      .half_sel (half),
      .clk_out  (div_out[d]),
      .live     (div_live[d])
    );
  end

  logic [LANES-1:0] c_lanes;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      c_lanes[i] = (i >= HALF_LANES) ? (div_out[2] ^ c_invert) : div_out[2];
    end
  end

  assign qa   = rst_oe_n ? {LANES{div_out[0]}} : 'z;
  assign qb   = rst_oe_n ? {LANES{div_out[1]}} : 'z;
  assign qc   = rst_oe_n ? c_lanes             : 'z;
  assign q_fb = rst_oe_n ? div_out[3]          : 1'bz;

  p_first_rise_r7: assert property (@(posedge src_clk) disable iff (!rst_oe_n)
    $rose(div_live[0]) |-> (&div_out && &div_live));

  p_start_together_r8: assert property (@(posedge src_clk) disable iff (!rst_oe_n)
    $rose(div_live[3]) |-> !$past(div_live[0]));
endmodule

// File: tb/test_tribank_clk_div.sv
module test_tribank_clk_div;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic vco_clk = 0, ref_clk = 0, pll_on = 1, rst_oe_n = 0, range_hi = 1, c_invert = 0;
  logic [1:0] sel_a = 0, sel_b = 0, sel_c = 0;
  logic [2:0] sel_fb = 0;
  wire  [3:0] qa, qb, qc;
  wire        q_fb;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_live = 0;
  int m_pos [4];
  int m_half[4];
  bit m_out [4];

  tribank_clk_div i_tribank_clk_div (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .pll_on(pll_on), .rst_oe_n(rst_oe_n),
    .range_hi(range_hi), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .sel_fb(sel_fb), .c_invert(c_invert), .qa(qa), .qb(qb), .qc(qc), .q_fb(q_fb)
  );

  function automatic int ratio_of(int d);
    int r;
    case (d)
      0: case (sel_a) 0: r = 4; 1: r = 6; 2: r = 8; default: r = 12; endcase
      1: case (sel_b) 0: r = 4; 1: r = 6; 2: r = 8; default: r = 10; endcase
      2: case (sel_c) 0: r = 2; 1: r = 4; 2: r = 6; default: r = 8; endcase
      default: case (sel_fb)
        0: r = 4; 1: r = 6; 2: r = 8; 3: r = 10;
        4: r = 8; 5: r = 12; 6: r = 16; default: r = 20;
      endcase
    endcase
    return range_hi ? r : 2 * r;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int d = 0; d < 4; d++) begin
      if (!m_live) begin
        m_half[d] = ratio_of(d) / 2;
        m_pos[d] = 0;
      end
      m_out[d] = (m_pos[d] < m_half[d]);
      m_pos[d]++;
      if (m_pos[d] == 2 * m_half[d]) begin
        m_pos[d] = 0;
        m_half[d] = ratio_of(d) / 2;
      end
    end
    m_live = 1;
  endtask

  task automatic compare_all();
    logic c;
    c = m_out[2];
    check("R1 bank A", qa, {4{m_out[0]}});
    check("R2 bank B", qb, {4{m_out[1]}});
    check("R3/R10 bank C", qc, {{2{c ^ c_invert}}, {2{c}}});
    check("R4 feedback", {3'b0, q_fb}, {3'b0, m_out[3]});
  endtask

  // one source edge; sample in the low phase
  task automatic step(bit do_check);
    if (pll_on) vco_clk = 1; else ref_clk = 1;
    if (rst_oe_n) model_step();
    #HALF;
    vco_clk = 0; ref_clk = 0;
    #(HALF / 2);
    if (do_check && rst_oe_n) compare_all();
    #(HALF / 2);
  endtask

  task automatic enter_reset();
    rst_oe_n = 0; m_live = 0;
    #1;
    check("R8 qa not driven high", {qa[0] === 1'b1, qa[1] === 1'b1, qa[2] === 1'b1, qa[3] === 1'b1}, 4'b0);
    check("R8 qc not driven high", {qc[0] === 1'b1, qc[1] === 1'b1, qc[2] === 1'b1, qc[3] === 1'b1}, 4'b0);
    for (int i = 0; i < 5; i++) step(0);
    check("R8 held while clocking", {qb[0] === 1'b1, qb[3] === 1'b1, q_fb === 1'b1, qa[0] === 1'b1}, 4'b0);
  endtask

  task automatic release_and_check_first();
    rst_oe_n = 1;
    step(1);
    check("R7 first edge all high", {qa[0], qb[0], qc[0], q_fb}, 4'b1111);
  endtask

  task automatic randomize_cfg();
    sel_a = 2'($urandom); sel_b = 2'($urandom); sel_c = 2'($urandom);
    sel_fb = 3'($urandom); range_hi = 1'($urandom); c_invert = 1'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold_a, hold_c;
    logic hold_fb;
    int hi_run, lo_run;
    void'($urandom(32'h5eed_1234));
    #(HALF / 2);

    // reset state (R8)
    enter_reset();

    // directed: fastest and slowest settings, range high (R1-R4, R6)
    sel_a = 0; sel_b = 3; sel_c = 0; sel_fb = 7; range_hi = 1; c_invert = 1;
    release_and_check_first();
    for (int i = 0; i < 80; i++) step(1);

    // directed duty on the longest ratio, range low: /40 (R4, R5, R6)
    enter_reset();
    sel_fb = 7; range_hi = 0;
    rst_oe_n = 1;
    hi_run = 0; lo_run = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (q_fb === 1'b1) hi_run++; else lo_run++;
    end
    check("R6 /40 high half", 4'(hi_run), 4'(20 % 16));
    check("R6 /40 low half", {3'b0, lo_run == 20}, 4'b0001);

    // random static configurations (R1-R5, R7, R10)
    for (int k = 0; k < 12; k++) begin
      enter_reset();
      randomize_cfg();
      release_and_check_first();
      for (int i = 0; i < 90; i++) step(1);
    end

    // select and range changes at random edges (R11)
    for (int k = 0; k < 8; k++) begin
      enter_reset();
      randomize_cfg();
      release_and_check_first();
      for (int i = 0; i < 160; i++) begin
        if ($urandom_range(0, 13) == 0) randomize_cfg();
        step(1);
      end
    end

    // bypass: reference clock drives the dividers (R9)
    enter_reset();
    pll_on = 0;
    randomize_cfg();
    release_and_check_first();
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (i % 10 == 3) begin
        hold_a = qa; hold_c = qc; hold_fb = q_fb;
        for (int j = 0; j < 6; j++) begin
          vco_clk = 1; #(HALF / 2); vco_clk = 0; #(HALF / 2);
        end
        check("R9 vco ignored in bypass qa", qa, hold_a);
        check("R9 vco ignored in bypass qc/fb", {qc[3:1], q_fb}, {hold_c[3:1], hold_fb});
      end
    end

    // reset in mid-run restarts everything aligned (R8, R7)
    pll_on = 1;
    for (int i = 0; i < 7; i++) step(1);
    enter_reset();
    release_and_check_first();
    for (int i = 0; i < 40; i++) step(1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule